// File: doc/BRIEF.md
# Microprogram Sequencer

This block decides which control-store word a microprogrammed controller reads next. It holds a 7-bit control address register and one return register for a single level of micro-subroutine. Every cycle it takes the decoded condition select, branch kind and address field of the current microword, together with the machine opcode, the indirect-mode flag and the accumulator sign and zero flags. It then loads the control address register with the next address: the sequential successor, the address field, the saved return address, or the start of the routine that belongs to the opcode.

The microword is 20 bits wide. It carries three 3-bit operation fields, which other logic decodes, a 2-bit condition select, a 2-bit branch kind and a 7-bit address field, so the control store holds 128 words. Only the last three fields reach this block. The opcode map gives each of the 16 opcodes a block of four consecutive words.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads the control address with 64 and clears the return register to 0.
- R2: The condition select encodes 00 as always true, 01 as the indirect-mode flag, 10 as the accumulator sign flag and 11 as the accumulator zero flag.
- R3: With branch kind 00 (jump), a true condition loads the address field and a false condition loads the current address plus one.
- R4: With branch kind 01 (call), a true condition loads the address field and writes the current address plus one into the return register. A false condition loads the current address plus one and leaves the return register unchanged.
- R5: With branch kind 10 (return), the control address is loaded from the return register whatever the condition, and the return register keeps its value.
- R6: With branch kind 11 (map), the control address becomes a zero bit, then the 4-bit opcode, then two zero bits (opcode times 4), whatever the condition.
- R7: The current address plus one is computed modulo 128, so address 127 is followed by address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Condition select field of the current microword |
| brk_sel | input | 2 | Branch kind field of the current microword |
| addr_fld | input | 7 | Address field of the current microword |
| opcode | input | 4 | Opcode of the fetched machine instruction |
| ind_bit | input | 1 | Indirect-mode flag of the fetched instruction |
| ac_sign | input | 1 | Accumulator sign flag |
| ac_zero | input | 1 | Accumulator-equals-zero flag |
| car_o | output | 7 | Control address for the next control-store read |

## Verification
A wrong control address shows on car_o one edge after the microword that caused it. Because every following sequential address depends on it, the error also persists in the cycles after. A return register that is corrupted or wrongly updated stays hidden until the next return branch, which can be many cycles later. For that reason the bench mixes calls, non-taken calls and returns in a long walk, so a stale or clobbered return value shows up on the first return after the bad update.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        CS_ALWAYS = 2'b00,
        CS_INDIR  = 2'b01,
        CS_NEG    = 2'b10,
        CS_ZERO   = 2'b11
    } cond_sel_e;

    typedef enum logic [1:0] {
        BK_JUMP = 2'b00,
        BK_CALL = 2'b01,
        BK_RET  = 2'b10,
        BK_MAP  = 2'b11
    } brk_kind_e;

endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
    import useq_pkg::*;
(
    input  cond_sel_e sel,
    input  logic      ind_bit,
    input  logic      ac_sign,
    input  logic      ac_zero,
    output logic      cond_true
);
    // R2: status flags indexed by the select code
    logic [3:0] flag_vec;

    always_comb begin
        flag_vec = {ac_zero, ac_sign, ind_bit, 1'b1};
        cond_true = flag_vec[sel];
    end

    always_comb begin
        if (sel == CS_ALWAYS)
            assert_always_true_R2: assert (cond_true === 1'b1 || $isunknown(sel));
    end
endmodule

// File: rtl/useq_map.sv
module useq_map #(
    parameter int ADDR_W    = 7,
    parameter int OPC_W     = 4,
    parameter int LOW_ZEROS = 2
) (
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] map_addr
);
    localparam int HI_ZEROS = ADDR_W - OPC_W - LOW_ZEROS;

    logic [OPC_W+LOW_ZEROS-1:0] low_part;

    generate
        if (LOW_ZEROS > 0) begin : g_low
            assign low_part = {opcode, {LOW_ZEROS{1'b0}}};
        end else begin : g_nolow
            assign low_part = opcode;
        end
        if (HI_ZEROS > 0) begin : g_hi
            assign map_addr = {{HI_ZEROS{1'b0}}, low_part};
        end else begin : g_nohi
            assign map_addr = low_part;
        end
    endgenerate
endmodule

// File: rtl/useq_incr.sv
module useq_incr #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // R7: wraps modulo 2**ADDR_W
    assign nxt = cur + ONE;
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OPC_W      = 4,
    parameter int MAP_LOW    = 2,
    parameter int RESET_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cond_sel,
    input  logic [1:0]        brk_sel,
    input  logic [ADDR_W-1:0] addr_fld,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              ind_bit,
    input  logic              ac_sign,
    input  logic              ac_zero,
    output logic [ADDR_W-1:0] car_o
);
    localparam logic [ADDR_W-1:0] RST_CAR = ADDR_W'(RESET_ADDR);
    localparam int                OPC_LO  = MAP_LOW;
    localparam int                OPC_HI  = MAP_LOW + OPC_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] car;
        logic [ADDR_W-1:0] ret;
    } seq_state_t;

    seq_state_t st_d, st_q;

    cond_sel_e         sel_e;
    brk_kind_e         brk_e;
    logic              taken;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] map_addr;

    assign sel_e = cond_sel_e'(cond_sel);
    assign brk_e = brk_kind_e'(brk_sel);

    useq_cond_sel u_cond (
        .sel       (sel_e),
        .ind_bit   (ind_bit),
        .ac_sign   (ac_sign),
        .ac_zero   (ac_zero),
        .cond_true (taken)
    );

    useq_incr #(.ADDR_W(ADDR_W)) u_incr (
        .cur (st_q.car),
        .nxt (seq_addr)
    );

    useq_map #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .LOW_ZEROS(MAP_LOW)) u_map (
        .opcode   (opcode),
        .map_addr (map_addr)
    );

    always_comb begin
        st_d = st_q;
        unique case (brk_e)
            BK_JUMP: st_d.car = taken ? addr_fld : seq_addr;
            BK_CALL: begin
                st_d.car = taken ? addr_fld : seq_addr;
                if (taken) st_d.ret = seq_addr;
            end
            BK_RET:  st_d.car = st_q.ret;
            BK_MAP:  st_d.car = map_addr;
            default: st_d.car = seq_addr;
        endcase
        if (rst) begin
            st_d.car = RST_CAR;
            st_d.ret = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign car_o = st_q.car;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (st_q.car == RST_CAR && st_q.ret == '0));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (brk_e == BK_JUMP && !taken) |=> st_q.car == ADDR_W'($past(st_q.car) + 1'b1));

    assert_call_link_R4: assert property (@(posedge clk) disable iff (rst)
        (brk_e == BK_CALL && taken) |=>
            (st_q.ret == ADDR_W'($past(st_q.car) + 1'b1) && st_q.car == $past(addr_fld)));

    assert_ret_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(brk_e == BK_CALL && taken) |=> $stable(st_q.ret));

    assert_return_R5: assert property (@(posedge clk) disable iff (rst)
        (brk_e == BK_RET) |=> st_q.car == $past(st_q.ret));

    assert_map_form_R6: assert property (@(posedge clk) disable iff (rst)
        (brk_e == BK_MAP) |=>
            (st_q.car[OPC_HI:OPC_LO] == $past(opcode) && st_q.car[ADDR_W-1] == 1'b0
             && st_q.car[1:0] == 2'b00));
endmodule

// File: tb/sim_useq_sequencer.sv
module sim_useq_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond_sel = '0;
    logic [1:0] brk_sel = '0;
    logic [6:0] addr_fld = '0;
    logic [3:0] opcode = '0;
    logic       ind_bit = 1'b0;
    logic       ac_sign = 1'b0;
    logic       ac_zero = 1'b0;
    logic [6:0] car_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [6:0] m_car;
    logic [6:0] m_ret;

    always #10 clk = ~clk;

    useq_sequencer u0 (
        .clk(clk), .rst(rst), .cond_sel(cond_sel), .brk_sel(brk_sel),
        .addr_fld(addr_fld), .opcode(opcode), .ind_bit(ind_bit),
        .ac_sign(ac_sign), .ac_zero(ac_zero), .car_o(car_o)
    );

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: car_o=%0d expected %0d", tag, act, exp);
        end
    endtask

    // one microword step; model computed from the requirements (R2..R7)
    task automatic step(input string tag, input logic [1:0] cs, input logic [1:0] bk,
                        input logic [6:0] ad, input logic [3:0] op,
                        input logic i, input logic s, input logic z);
        logic t;
        logic [6:0] inc;
        @(negedge clk);
        cond_sel = cs; brk_sel = bk; addr_fld = ad; opcode = op;
        ind_bit = i; ac_sign = s; ac_zero = z;
        t = (cs == 2'd0) ? 1'b1 : (cs == 2'd1) ? i : (cs == 2'd2) ? s : z;
        inc = m_car + 7'd1;
        case (bk)
            2'd0: m_car = t ? ad : inc;
            2'd1: begin
                if (t) m_ret = inc;
                m_car = t ? ad : inc;
            end
            2'd2: m_car = m_ret;
            default: m_car = {1'b0, op, 2'b00};
        endcase
        @(posedge clk); #1;
        check(tag, car_o, m_car);
    endtask

    function automatic string kind_tag(input logic [1:0] bk);
        case (bk)
            2'd0: return "R3 jump (R2 cond)";
            2'd1: return "R4 call (R2 cond)";
            2'd2: return "R5 return";
            default: return "R6 map";
        endcase
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset address", car_o, 7'd64);
        @(negedge clk);
        rst = 1'b0;
        m_car = 7'd64;
        m_ret = 7'd0;
        // R1: return right after reset exposes the cleared return register
        step("R1 return register cleared", 2'd3, 2'd2, 7'd55, 4'd0, 1'b1, 1'b1, 1'b1);

        // R7: wrap of the sequential successor
        step("R7 jump to top", 2'd0, 2'd0, 7'd127, 4'd0, 1'b0, 1'b0, 1'b0);
        step("R7 wrap to zero", 2'd1, 2'd0, 7'd9, 4'd0, 1'b0, 1'b0, 1'b0);
        step("R7 jump to top again", 2'd0, 2'd0, 7'd127, 4'd0, 1'b0, 1'b0, 1'b0);
        step("R7 call from top", 2'd0, 2'd1, 7'd33, 4'd0, 1'b0, 1'b0, 1'b0);
        step("R7 return to wrapped link", 2'd0, 2'd2, 7'd3, 4'd0, 1'b0, 1'b0, 1'b0);

        // exhaustive sweep of branch kind x condition x flags, several addresses
        for (int bk = 0; bk < 4; bk++)
            for (int cs = 0; cs < 4; cs++)
                for (int f = 0; f < 8; f++)
                    for (int k = 0; k < 4; k++)
                        step(kind_tag(2'(bk)), 2'(cs), 2'(bk),
                             7'((bk * 37 + cs * 11 + f * 5 + k * 29) % 128),
                             4'((f + k * 3 + cs) % 16), f[0], f[1], f[2]);

        // interleaved walk: calls, non-taken calls and returns mixed
        for (int n = 0; n < 400; n++)
            step(kind_tag(2'((n * 7 + n / 5) % 4)), 2'((n * 3) % 4), 2'((n * 7 + n / 5) % 4),
                 7'((n * 53 + 17) % 128), 4'((n * 5) % 16), n[1], n[2], n[3]);

        // R1: reset mid-run restores both registers
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset mid-run", car_o, 7'd64);
        @(negedge clk); rst = 1'b0;
        m_car = 7'd64; m_ret = 7'd0;
        step("R1 return after mid-run reset", 2'd2, 2'd2, 7'd1, 4'd0, 1'b0, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, car_o=%0d expected completion", car_o);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule